// File: doc/BRIEF.md
# Store-and-Forward Transmit Packet Gate

This block sits beside a packet FIFO that feeds an Ethernet MAC transmitter. It watches the stream handshake on both sides of that FIFO and keeps a count of the whole packets stored inside it. A packet is counted in when its final beat (the beat with the last flag) is accepted at the FIFO input. It is counted out when its final beat is accepted at the FIFO output. The FIFO itself is not part of the block.

From that count the block drives a single send enable. The enable rises only between packets, and only when at least one complete packet is stored and the MAC is not reporting full. Once it is up it stays up until the current packet's last beat has been taken. The enable drives the FIFO output ready directly and masks the valid and start-of-frame flags passed to the MAC. As a result a transmission never begins on a partly written packet and the MAC cannot run dry in the middle of a frame.

Top module: `tx_pkt_gate`

## Requirements
- R1: After synchronous reset `rst`, `fifoReady`, `macValid` and `macSof` are 0 whatever `fifoValid` and `fifoSof` are.
- R2: A packet is counted in only on a cycle where `inValid`, `inReady` and `inLast` are all 1. Non-last beats, and last beats that are not accepted, do not make the enable rise.
- R3: If the gate is idle, at least one packet is stored and `macFull` is 0, `fifoReady` rises on the clock edge after the edge that stored the packet's last beat. It is still 0 in the cycle between those two edges.
- R4: While the gate is idle, `macFull` = 1 keeps `fifoReady` at 0 even when packets are stored. `fifoReady` rises on the first edge after `macFull` returns to 0.
- R5: Once `fifoReady` is 1 it stays 1 until a beat with `fifoValid` = 1 and `fifoLast` = 1 is accepted. This holds through output stalls and through `macFull` going high. It falls on that edge.
- R6: After each packet leaves there is at least one idle cycle with `fifoReady` = 0. If further packets are stored, `fifoReady` rises again on the next edge. If none are stored it stays 0.
- R7: If a packet is counted in and another counted out on the same edge, the count does not change.
- R8: `fifoReady` equals the send enable, `macValid` = `fifoValid` AND enable, and `macSof` = `fifoSof` AND enable.
- R9: The count holds up to `MAX_PKTS` packets without wrapping. After exactly `MAX_PKTS` packets are stored, exactly `MAX_PKTS` send windows follow, and then the gate stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | FIFO input-side valid (observed) |
| inReady | input | 1 | FIFO input-side ready (observed) |
| inLast | input | 1 | FIFO input-side last-beat flag (observed) |
| fifoValid | input | 1 | FIFO output valid |
| fifoLast | input | 1 | FIFO output last-beat flag |
| fifoSof | input | 1 | FIFO output start-of-frame flag |
| macFull | input | 1 | MAC transmit-full indication |
| fifoReady | output | 1 | Ready to FIFO output; the send enable |
| macValid | output | 1 | Valid to MAC, masked by the enable |
| macSof | output | 1 | Start-of-frame to MAC, masked by the enable |

## Verification
If the packet count is too high, `fifoReady` comes up on an empty or partial FIFO. This shows as an extra send window one edge after the previous packet ends. If the count is too low, a stored packet is never released and `fifoReady` stays low indefinitely. A corrupt enable state shows on the very next cycle as `macValid` following `fifoValid` between packets, or as the enable dropping in the middle of a packet. The bench therefore checks the exact edge on which the enable rises and falls, and counts the send windows after fills and drains that cross in the same cycle.

// File: rtl/tx_pkt_gate_pkg.sv
package tx_pkt_gate_pkg;

  // Strobes issued by the control toward the packet counter.
  typedef struct packed {
    logic countIn;
    logic countOut;
  } gateStrobes_t;

endpackage

// File: rtl/tx_pkt_gate_counter.sv
module tx_pkt_gate_counter
  import tx_pkt_gate_pkg::*;
#(
  parameter int MAX_PKTS = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  gateStrobes_t strobes,
  output logic         pktAvail,
  output logic         atCapacity
);

  localparam int CNT_W = $clog2(MAX_PKTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PKTS);

  logic [CNT_W-1:0] pktCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      pktCount <= '0;
    end else begin
      case ({strobes.countIn, strobes.countOut})
        2'b10:   pktCount <= pktCount + CNT_W'(1);
        2'b01:   pktCount <= pktCount - CNT_W'(1);
        default: pktCount <= pktCount;
      endcase
    end
  end

  assign pktAvail   = (pktCount != '0);
  assign atCapacity = (pktCount == CNT_MAX);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(atCapacity && strobes.countIn && !strobes.countOut)); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    strobes.countOut |-> pktAvail); // R6

  AST_BALANCED_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strobes.countIn && strobes.countOut) |=> $stable(pktCount)); // R7

endmodule

// File: rtl/tx_pkt_gate_ctrl.sv
module tx_pkt_gate_ctrl
  import tx_pkt_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inReady,
  input  logic         inLast,
  input  logic         fifoValid,
  input  logic         fifoLast,
  input  logic         macFull,
  input  logic         pktAvail,
  output gateStrobes_t strobes,
  output logic         sendEn
);

  logic lastOut;

  assign lastOut          = sendEn && fifoValid && fifoLast;
  assign strobes.countIn  = inValid && inReady && inLast;
  assign strobes.countOut = lastOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      sendEn <= 1'b0;
    end else if (sendEn) begin
      if (lastOut) sendEn <= 1'b0;
    end else if (pktAvail && !macFull) begin
      sendEn <= 1'b1;
    end
  end

  AST_HOLD_TO_LAST: assert property (@(posedge clk) disable iff (rst)
    (sendEn && !(fifoValid && fifoLast)) |=> sendEn); // R5

  AST_START_GUARDED: assert property (@(posedge clk) disable iff (rst)
    $rose(sendEn) |-> $past(pktAvail && !macFull)); // R4

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    lastOut |=> !sendEn); // R6

endmodule

// File: rtl/tx_pkt_gate.sv
module tx_pkt_gate
  import tx_pkt_gate_pkg::*;
#(
  parameter int MAX_PKTS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic inReady,
  input  logic inLast,
  input  logic fifoValid,
  input  logic fifoLast,
  input  logic fifoSof,
  input  logic macFull,
  output logic fifoReady,
  output logic macValid,
  output logic macSof
);

  gateStrobes_t strobes;
  logic         pktAvail;
  logic         atCapacity;
  logic         sendEn;

  tx_pkt_gate_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inReady   (inReady),
    .inLast    (inLast),
    .fifoValid (fifoValid),
    .fifoLast  (fifoLast),
    .macFull   (macFull),
    .pktAvail  (pktAvail),
    .strobes   (strobes),
    .sendEn    (sendEn)
  );

  tx_pkt_gate_counter #(.MAX_PKTS(MAX_PKTS)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .pktAvail   (pktAvail),
    .atCapacity (atCapacity)
  );

  assign fifoReady = sendEn;
  assign macValid  = fifoValid && sendEn;
  assign macSof    = fifoSof && sendEn;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !fifoReady); // R1

endmodule

// File: tb/sim_tx_pkt_gate.sv
`timescale 1ns/1ps
module sim_tx_pkt_gate;

  localparam int NPKT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 0, inReady = 0, inLast = 0;
  logic fifoValid = 0, fifoLast = 0, fifoSof = 0, macFull = 0;
  logic fifoReady, macValid, macSof;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tx_pkt_gate #(.MAX_PKTS(NPKT)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inLast(inLast),
    .fifoValid(fifoValid), .fifoLast(fifoLast), .fifoSof(fifoSof), .macFull(macFull),
    .fifoReady(fifoReady), .macValid(macValid), .macSof(macSof)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEn(input string tag, input logic exp);
    chk(fifoReady === exp, tag, int'(fifoReady), int'(exp));
  endtask

  // Push a packet of len beats through the input handshake; returns at the
  // falling edge after the edge that accepted the last beat.
  task automatic pushPkt(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1; inReady = 1; inLast = (i == len - 1);
    end
    @(negedge clk);
    inValid = 0; inReady = 0; inLast = 0;
  endtask

  // Offer len beats at the FIFO output; returns at the falling edge after
  // the edge that consumed the last beat.
  task automatic drainPkt(input int len);
    int i = 0;
    while (i < len) begin
      @(negedge clk);
      fifoValid = 1; fifoLast = (i == len - 1);
      if (fifoReady) i++;
      @(posedge clk);
    end
    @(negedge clk);
    fifoValid = 0; fifoLast = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    fifoValid = 1; fifoSof = 1;
    @(negedge clk);
    chkEn("R1 ready after reset", 1'b0);
    chk(macValid === 0, "R1 macValid after reset", int'(macValid), 0);
    chk(macSof === 0, "R1 macSof after reset", int'(macSof), 0);
    fifoValid = 0; fifoSof = 0;
  endtask

  task automatic t_ignore;
    @(negedge clk); inValid = 1; inReady = 1; inLast = 0;
    @(negedge clk); inValid = 1; inReady = 0; inLast = 1;
    @(negedge clk); inValid = 0; inReady = 1; inLast = 1;
    @(negedge clk); inValid = 0; inReady = 0; inLast = 0;
    idle(3);
    chkEn("R2 unaccepted or non-last beats ignored", 1'b0);
  endtask

  task automatic t_rise_hold;
    pushPkt(3);
    chkEn("R3 not yet enabled", 1'b0);
    @(negedge clk);
    chkEn("R3 enabled one edge later", 1'b1);
    fifoValid = 1; fifoSof = 1;
    #1;
    chk(macValid === 1, "R8 macValid passes", int'(macValid), 1);
    chk(macSof === 1, "R8 macSof passes", int'(macSof), 1);
    fifoValid = 0; fifoSof = 0; macFull = 1;
    idle(3);
    chkEn("R5 held through stall and full", 1'b1);
    macFull = 0;
    drainPkt(3);
    chkEn("R5 drops after last beat", 1'b0);
    idle(2);
    chkEn("R6 stays idle when empty", 1'b0);
    fifoValid = 1; fifoSof = 1;
    #1;
    chk(macValid === 0, "R8 macValid masked", int'(macValid), 0);
    chk(macSof === 0, "R8 macSof masked", int'(macSof), 0);
    fifoValid = 0; fifoSof = 0;
  endtask

  task automatic t_full;
    macFull = 1;
    pushPkt(2);
    idle(4);
    chkEn("R4 full blocks start", 1'b0);
    macFull = 0;
    @(negedge clk);
    chkEn("R4 starts after full clears", 1'b1);
    drainPkt(2);
    chkEn("R4 packet drained", 1'b0);
  endtask

  task automatic t_simul;
    pushPkt(1);
    @(negedge clk);
    chkEn("R7 first packet enabled", 1'b1);
    fifoValid = 1; fifoLast = 1;
    inValid = 1; inReady = 1; inLast = 1;
    @(negedge clk);
    fifoValid = 0; fifoLast = 0;
    inValid = 0; inReady = 0; inLast = 0;
    chkEn("R7 idle gap after crossing", 1'b0);
    @(negedge clk);
    chkEn("R7 one packet remains", 1'b1);
    drainPkt(1);
    idle(2);
    chkEn("R7 none remains", 1'b0);
  endtask

  task automatic t_back2back;
    pushPkt(2);
    pushPkt(1);
    @(negedge clk);
    drainPkt(2);
    chkEn("R6 idle cycle between packets", 1'b0);
    @(negedge clk);
    chkEn("R6 next packet re-enabled", 1'b1);
    drainPkt(1);
    idle(2);
    chkEn("R6 idle after both", 1'b0);
  endtask

  task automatic t_fill;
    int windows = 0;
    for (int p = 0; p < NPKT; p++) pushPkt(2);
    for (int w = 0; w < NPKT + 2; w++) begin
      idle(1);
      if (fifoReady) begin
        windows++;
        drainPkt(2);
      end
    end
    chk(windows == NPKT, "R9 windows after fill to capacity", windows, NPKT);
    chkEn("R9 idle after drain", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ignore();
    t_rise_hold();
    t_full();
    t_simul();
    t_back2back();
    t_fill();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule